// File: doc/BRIEF.md
# Serial Peripheral Master with Framed Select

This block is a synchronous serial master. It sends words on a data-out line and captures words from a data-in line. A bit clock is produced by dividing the single system clock. The idle level of the bit clock is selectable, and so is the edge on which data is captured. An active-low select output frames each transfer. The select asserts a fixed time before the first clock edge and releases a fixed time after the last capturing edge.

Words enter through a valid/ready port that has one holding slot. A second word can therefore wait while the current one is shifting. When that word is present at the moment the current word completes, it follows with no pause in the bit clock, and the select stays low across the boundary. Each captured word leaves on a data port together with a one-cycle strobe.

The clock settings (polarity, phase, divider) and the word length are taken from the configuration inputs only while the block is idle. Changes made during a transfer wait until the block is idle again.

Top module: `spi_frame_master`

## Requirements
- R1: With a divider value D of 3 or more, one bit-clock period lasts D+1 system cycles. It is split into floor((D+1)/2) cycles followed by the remaining cycles, and consecutive leading edges are exactly D+1 cycles apart.
- R2: Divider values 0, 1 and 2 all give a bit-clock period of 4 system cycles.
- R3: While the select is high, the bit clock rests at the level given by the polarity input: 0 rests low, 1 rests high.
- R4: Phase 0: the first data bit is on the data-out line half a period before the first edge. Data is captured on leading edges (edges that leave the rest level) and changed on trailing edges.
- R5: Phase 1: data-out changes on each leading edge, and data-in is captured on each trailing edge.
- R6: Words are shifted most significant bit first. The length field gives 1 to 16 bits, and a length of 0 or greater than 16 means 16. The low bits of the transmit word are the ones sent.
- R7: The select falls P + floor(P/2) system cycles before the first leading edge of a frame, where P is the bit-clock period.
- R8: The select rises exactly P system cycles after the capturing edge of the last bit, and it is high whenever the block is not busy.
- R9: A word already waiting when the current word finishes starts at once. The select does not rise between the two words, and the leading-edge spacing stays P.
- R10: Each received word appears on the receive data port with a strobe that is high for exactly one cycle. The first received bit is the most significant bit of the word, and all bits above the word length are 0.
- R11: Changes to polarity, phase, divider or length made while the block is busy do not affect the transfer in progress. They are used for the next frame that starts from idle.
- R12: The transmit ready output is low while a word is waiting in the holding slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Bit-clock rest level |
| cfg_cpha | input | 1 | Capture edge select (0 leading, 1 trailing) |
| cfg_brr | input | DIV_W | Divider value D |
| cfg_len | input | LEN_W | Word length in bits |
| tx_data | input | WORD_W | Word to send, right-aligned |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding slot free |
| rx_data | output | WORD_W | Received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| busy | output | 1 | A frame is in progress |
| sclk | output | 1 | Bit clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low select |

## Verification
The bench drives all four polarity and phase combinations against a slave model that captures and returns data according to the configured phase, so a swapped capture edge shows up as corrupted words. Divider values of 0, 2, 4, 5, 7 and 9 separate the floor case from the linear case, and the odd periods expose any error in how a period is split into halves. Word lengths of 1, 5, 8, 16 and 0 test alignment and the out-of-range rule. A three-word burst separates back-to-back framing from a frame per word. A change to the divider and length in the middle of a frame shows whether the configuration is frozen during a transfer.

// File: rtl/spi_fm_pkg.sv
`timescale 1ns/1ps
package spi_fm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_LAG   = 2'd3
    } fm_state_e;

    typedef struct packed {
        logic cpol;
        logic cpha;
    } fm_mode_t;

    typedef struct packed {
        logic load;
        logic drive;
        logic sample;
        logic last;
    } fm_step_t;

    localparam int unsigned FM_MIN_PERIOD = 4;

    function automatic int unsigned fm_period(input int unsigned brr);
        return (brr < FM_MIN_PERIOD - 1) ? FM_MIN_PERIOD : brr + 1;
    endfunction

    function automatic int unsigned fm_len_eff(input int unsigned len, input int unsigned maxw);
        return (len == 0 || len > maxw) ? maxw : len;
    endfunction

endpackage

// File: rtl/spi_fm_timer.sv
`timescale 1ns/1ps
module spi_fm_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             odd,
    input  logic [CNT_W-1:0] half_lo,
    input  logic [CNT_W-1:0] half_hi,
    output logic             slot_end
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] span;

    assign span     = odd ? half_hi : half_lo;
    assign slot_end = run && (cnt == span - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run || slot_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_fm_hold.sv
`timescale 1ns/1ps
module spi_fm_hold #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    input  logic              pop,
    output logic              full,
    output logic [WORD_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (push && !full) begin
            full <= 1'b1;
            data <= push_data;
        end else if (pop) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_fm_shifter.sv
`timescale 1ns/1ps
module spi_fm_shifter #(
    parameter int WORD_W = 16,
    parameter int LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              drive_now,
    input  logic [WORD_W-1:0] load_data,
    input  logic [LEN_W-1:0]  len,
    input  logic              drive,
    input  logic              sample,
    input  logic              miso,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_next
);
    logic [WORD_W-1:0] tx_sr;
    logic [WORD_W-1:0] rx_sr;
    logic [WORD_W-1:0] aligned;

    assign aligned = load_data << (LEN_W'(WORD_W) - len);
    assign rx_next = {rx_sr[WORD_W-2:0], miso};

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr <= '0;
            rx_sr <= '0;
            mosi  <= 1'b0;
        end else begin
            if (load) begin
                rx_sr <= '0;
                if (drive_now) begin
                    mosi  <= aligned[WORD_W-1];
                    tx_sr <= aligned << 1;
                end else begin
                    tx_sr <= aligned;
                end
            end else begin
                if (sample) begin
                    rx_sr <= rx_next;
                end
                if (drive) begin
                    mosi  <= tx_sr[WORD_W-1];
                    tx_sr <= tx_sr << 1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_frame_master.sv
`timescale 1ns/1ps
module spi_frame_master
    import spi_fm_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DIV_W  = 8,
    localparam int LEN_W  = $clog2(WORD_W + 1),
    localparam int CNT_W  = DIV_W + 1,
    localparam int SLOT_W = $clog2(2 * WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [DIV_W-1:0]  cfg_brr,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    fm_state_e         state;
    fm_mode_t          mode_q;
    fm_step_t          step;
    logic [CNT_W-1:0]  half_lo_q;
    logic [CNT_W-1:0]  half_hi_q;
    logic [LEN_W-1:0]  len_q;
    logic [SLOT_W-1:0] slot_idx;
    logic [SLOT_W-1:0] last_slot;
    logic [LEN_W:0]    slots_m1;
    logic [CNT_W-1:0]  period_in;
    logic              slot_end;
    logic              hold_full;
    logic [WORD_W-1:0] hold_data;
    logic [WORD_W-1:0] rx_next;
    logic              at_last;
    logic              even_slot;
    logic              sclk_q;

    assign period_in = CNT_W'(fm_period(int'(cfg_brr)));
    assign slots_m1  = {len_q, 1'b0} - 1'b1;
    assign last_slot = SLOT_W'(slots_m1);
    assign at_last   = (slot_idx == last_slot);
    assign even_slot = !slot_idx[0];
    assign busy      = (state != ST_IDLE);
    assign tx_ready  = !hold_full;
    assign sclk      = sclk_q;

    always_comb begin
        step = '0;
        if (slot_end && state == ST_LEAD && slot_idx[0]) begin
            step.load = 1'b1;
        end
        if (slot_end && state == ST_SHIFT) begin
            step.sample = mode_q.cpha ? !even_slot : even_slot;
            step.drive  = mode_q.cpha ? even_slot : (!even_slot && !at_last);
            step.last   = step.sample &&
                          (mode_q.cpha ? at_last : (slot_idx == last_slot - 1'b1));
            step.load   = at_last && hold_full;
        end
    end

    spi_fm_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .odd      (slot_idx[0]),
        .half_lo  (half_lo_q),
        .half_hi  (half_hi_q),
        .slot_end (slot_end)
    );

    spi_fm_hold #(.WORD_W(WORD_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .push      (tx_valid),
        .push_data (tx_data),
        .pop       (step.load),
        .full      (hold_full),
        .data      (hold_data)
    );

    spi_fm_shifter #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (step.load),
        .drive_now (!mode_q.cpha),
        .load_data (hold_data),
        .len       (len_q),
        .drive     (step.drive),
        .sample    (step.sample),
        .miso      (miso),
        .mosi      (mosi),
        .rx_next   (rx_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cs_n      <= 1'b1;
            sclk_q    <= cfg_cpol;
            slot_idx  <= '0;
            mode_q    <= '0;
            half_lo_q <= CNT_W'(FM_MIN_PERIOD / 2);
            half_hi_q <= CNT_W'(FM_MIN_PERIOD / 2);
            len_q     <= LEN_W'(WORD_W);
            rx_valid  <= 1'b0;
            rx_data   <= '0;
        end else begin
            rx_valid <= step.last;
            if (step.last) begin
                rx_data <= rx_next;
            end
            case (state)
                ST_IDLE: begin
                    sclk_q      <= cfg_cpol;
                    mode_q.cpol <= cfg_cpol;
                    mode_q.cpha <= cfg_cpha;
                    half_lo_q   <= period_in >> 1;
                    half_hi_q   <= period_in - (period_in >> 1);
                    len_q       <= LEN_W'(fm_len_eff(int'(cfg_len), WORD_W));
                    slot_idx    <= '0;
                    if (hold_full) begin
                        state <= ST_LEAD;
                        cs_n  <= 1'b0;
                    end
                end
                ST_LEAD: begin
                    if (slot_end) begin
                        if (slot_idx[0]) begin
                            state    <= ST_SHIFT;
                            slot_idx <= '0;
                        end else begin
                            slot_idx <= slot_idx + 1'b1;
                        end
                    end
                end
                ST_SHIFT: begin
                    if (slot_end) begin
                        sclk_q <= ~sclk_q;
                        if (at_last) begin
                            slot_idx <= '0;
                            if (!hold_full) begin
                                state <= ST_LAG;
                            end
                        end else begin
                            slot_idx <= slot_idx + 1'b1;
                        end
                    end
                end
                default: begin
                    if (slot_end) begin
                        if (slot_idx == SLOT_W'(mode_q.cpha)) begin
                            state    <= ST_IDLE;
                            cs_n     <= 1'b1;
                            slot_idx <= '0;
                        end else begin
                            slot_idx <= slot_idx + 1'b1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/spi_fm_checker.sv
`timescale 1ns/1ps
module spi_fm_checker #(
    parameter int LEN_W = 5,
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             cs_n,
    input logic             sclk,
    input logic             cfg_cpol,
    input logic             rx_valid,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [LEN_W-1:0] len_q,
    input logic [CNT_W-1:0] half_lo_q,
    input logic [CNT_W-1:0] half_hi_q,
    input logic [1:0]       mode_bits
);
    AST_CS_HIGH_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cs_n); // R8

    AST_SCLK_PARKS_AT_POLARITY: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |-> (sclk == $past(cfg_cpol))); // R3

    AST_RX_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R10

    AST_SCLK_HALF_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$stable(sclk)) |=> $stable(sclk)); // R2

    AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(len_q) && $stable(half_lo_q) &&
                                   $stable(half_hi_q) && $stable(mode_bits))); // R11

    AST_READY_DROPS_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_ready); // R12
endmodule

bind spi_frame_master spi_fm_checker #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_fm_checker (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .cfg_cpol  (cfg_cpol),
    .rx_valid  (rx_valid),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .len_q     (len_q),
    .half_lo_q (half_lo_q),
    .half_hi_q (half_hi_q),
    .mode_bits (mode_q)
);

// File: tb/test_spi_frame_master.sv
`timescale 1ns/1ps
module test_spi_frame_master;
    localparam int WORD_W = 16;
    localparam int DIV_W  = 8;
    localparam int LEN_W  = $clog2(WORD_W + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_cpol = 1'b0;
    logic              cfg_cpha = 1'b0;
    logic [DIV_W-1:0]  cfg_brr = '0;
    logic [LEN_W-1:0]  cfg_len = LEN_W'(8);
    logic [WORD_W-1:0] tx_data = '0;
    logic              tx_valid = 1'b0;
    logic              tx_ready;
    logic [WORD_W-1:0] rx_data;
    logic              rx_valid;
    logic              busy;
    logic              sclk;
    logic              mosi;
    logic              miso_r = 1'b0;
    logic              cs_n;

    always #2.5 clk = ~clk;

    spi_frame_master #(.WORD_W(WORD_W), .DIV_W(DIV_W)) i_spi_frame_master (
        .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_brr(cfg_brr), .cfg_len(cfg_len), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
        .rx_valid(rx_valid), .busy(busy), .sclk(sclk), .mosi(mosi),
        .miso(miso_r), .cs_n(cs_n)
    );

    // settings of the frame being observed, written by the stimulus only
    int unsigned cur_len = 8;
    logic        cur_cpol = 1'b0;
    logic        cur_cpha = 1'b0;
    string       cur_tag = "R6";

    logic [WORD_W-1:0] exp_mosi[$];
    logic [WORD_W-1:0] exp_rx[$];
    logic [WORD_W-1:0] reply_q[$];

    // monitor-owned state
    int                mon_checks = 0;
    int                mon_fails = 0;
    int                cyc = 0;
    int                win_start = 0;
    int                last_lead = 0;
    int                last_recv = 0;
    int                lmin = 0;
    int                lmax = 0;
    int                w_lead = 0;
    int                win_lead = 0;
    int                win_lag = 0;
    int                win_min = 0;
    int                win_max = 0;
    int                cs_rises = 0;
    int                bitn = 0;
    bit                first_lead = 0;
    bit                have_reply = 0;
    logic              prev_sclk = 1'b0;
    logic              prev_cs = 1'b1;
    logic [WORD_W-1:0] rxw = '0;
    logic [WORD_W-1:0] cur_reply = '0;

    int tb_checks = 0;
    int tb_fails = 0;

    function automatic logic [WORD_W-1:0] mask_of(input int unsigned len);
        return (len >= WORD_W) ? {WORD_W{1'b1}} : WORD_W'((1 << len) - 1);
    endfunction

    task automatic mon_finish();
        logic [WORD_W-1:0] e;
        mon_checks++;
        if (exp_mosi.size() == 0) begin
            mon_fails++;
            $display("FAIL %s: slave saw word %h, expected none", cur_cpha ? "R5" : "R4", rxw);
        end else begin
            e = exp_mosi.pop_front();
            if (rxw !== e) begin
                mon_fails++;
                $display("FAIL %s/%s: data-out word %h, expected %h",
                         cur_cpha ? "R5" : "R4", cur_tag, rxw, e);
            end
        end
        bitn = 0;
        rxw = '0;
        have_reply = 0;
        if (reply_q.size() > 0) begin
            cur_reply = reply_q.pop_front();
            have_reply = 1;
        end
    endtask

    // slave model, timing probe and receive scoreboard
    always @(negedge clk) begin
        bit lead;
        logic [WORD_W-1:0] e;
        cyc++;
        if (!rst) begin
            if (prev_cs && !cs_n) begin
                win_start = cyc; first_lead = 0; lmin = 1000000; lmax = 0;
                bitn = 0; rxw = '0;
                if (!have_reply && reply_q.size() > 0) begin
                    cur_reply = reply_q.pop_front();
                    have_reply = 1;
                end
                if (!cur_cpha) miso_r = cur_reply[cur_len-1];
            end
            if (!cs_n && sclk !== prev_sclk) begin
                lead = (prev_sclk == cur_cpol);
                if (lead) begin
                    if (!first_lead) begin
                        w_lead = cyc - win_start;
                        first_lead = 1;
                    end else begin
                        if (cyc - last_lead < lmin) lmin = cyc - last_lead;
                        if (cyc - last_lead > lmax) lmax = cyc - last_lead;
                    end
                    last_lead = cyc;
                end
                if (!cur_cpha) begin
                    if (lead) begin
                        rxw = (rxw << 1) | WORD_W'(mosi);
                        bitn++;
                        last_recv = cyc;
                    end else if (bitn == int'(cur_len)) begin
                        mon_finish();
                        if (have_reply) miso_r = cur_reply[cur_len-1];
                    end else begin
                        miso_r = cur_reply[cur_len-1-bitn];
                    end
                end else begin
                    if (lead) begin
                        miso_r = cur_reply[cur_len-1-bitn];
                    end else begin
                        rxw = (rxw << 1) | WORD_W'(mosi);
                        bitn++;
                        last_recv = cyc;
                        if (bitn == int'(cur_len)) mon_finish();
                    end
                end
            end
            if (!prev_cs && cs_n) begin
                win_lead = w_lead; win_lag = cyc - last_recv;
                win_min = lmin; win_max = lmax; cs_rises++;
            end
            if (rx_valid) begin
                mon_checks++;
                if (exp_rx.size() == 0) begin
                    mon_fails++;
                    $display("FAIL R10: rx word %h, expected none", rx_data);
                end else begin
                    e = exp_rx.pop_front();
                    if (rx_data !== e) begin
                        mon_fails++;
                        $display("FAIL R10/%s: rx word %h, expected %h", cur_tag, rx_data, e);
                    end
                end
            end
        end
        prev_sclk = sclk;
        prev_cs = cs_n;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        tb_checks++;
        if (!ok) begin
            tb_fails++;
            $display("FAIL %s: got %0d, expected %0d", tag, act, expv);
        end
    endtask

    task automatic send(input logic [WORD_W-1:0] d, input logic [WORD_W-1:0] rep);
        logic [WORD_W-1:0] m;
        m = mask_of(cur_len);
        exp_mosi.push_back(d & m);
        exp_rx.push_back(rep & m);
        reply_q.push_back(rep);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data = d;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy || !tx_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic set_mode(input bit pol, input bit pha, input int brr, input int len);
        cfg_cpol = pol; cfg_cpha = pha; cfg_brr = DIV_W'(brr); cfg_len = LEN_W'(len);
        cur_cpol = pol; cur_cpha = pha;
        cur_len = (len == 0 || len > WORD_W) ? WORD_W : len;
        repeat (2) @(negedge clk);
    endtask

    task automatic timing_chk(input int p, input string tag);
        chk(win_min == p && win_max == p, tag, win_max, p);
        chk(win_lead == p + p / 2, "R7", win_lead, p + p / 2);
        chk(win_lag == p, "R8", win_lag, p);
    endtask

    initial begin
        int rises0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n === 1'b1 && busy === 1'b0, "R8", int'(cs_n), 1);
        chk(sclk === 1'b0, "R3", int'(sclk), 0);
        chk(tx_ready === 1'b1 && rx_valid === 1'b0, "R12", int'(tx_ready), 1);

        // mode 0, divider 7 -> period 8
        set_mode(0, 0, 7, 8); cur_tag = "R4";
        send(16'h00A5, 16'h003C);
        chk(tx_ready === 1'b0, "R12", int'(tx_ready), 0);
        wait_idle();
        timing_chk(8, "R1");

        // floor of the divider
        set_mode(0, 0, 0, 8); cur_tag = "R2";
        send(16'h0081, 16'h007E);
        wait_idle();
        timing_chk(4, "R2");
        set_mode(0, 0, 2, 8);
        send(16'h0055, 16'h00C3);
        wait_idle();
        timing_chk(4, "R2");

        // polarity 1, phase 1, odd period 5, full length
        set_mode(1, 1, 4, 16); cur_tag = "R5";
        chk(sclk === 1'b1, "R3", int'(sclk), 1);
        send(16'hC0DE, 16'h1F2E);
        wait_idle();
        timing_chk(5, "R1");
        chk(sclk === 1'b1, "R3", int'(sclk), 1);

        // polarity 1, phase 0, short word
        set_mode(1, 0, 5, 5); cur_tag = "R6";
        send(16'hFFF3, 16'h0015);
        wait_idle();
        timing_chk(6, "R1");

        // polarity 0, phase 1, single bit and out-of-range length
        set_mode(0, 1, 3, 1); cur_tag = "R6";
        send(16'h0001, 16'h0000);
        send(16'h0000, 16'h0001);
        wait_idle();
        set_mode(0, 1, 3, 0);
        send(16'h8001, 16'hA5A5);
        wait_idle();
        chk(win_max == 4, "R6", win_max, 4);

        // back-to-back burst keeps the select low
        set_mode(0, 0, 4, 8); cur_tag = "R9";
        rises0 = cs_rises;
        send(16'h0011, 16'h00EE);
        send(16'h0022, 16'h00DD);
        send(16'h0033, 16'h00CC);
        wait_idle();
        chk(cs_rises - rises0 == 1, "R9", cs_rises - rises0, 1);
        chk(win_min == 5 && win_max == 5, "R9", win_min, 5);

        // configuration change during a frame
        set_mode(0, 0, 9, 8); cur_tag = "R11";
        send(16'h0096, 16'h0069);
        while (!busy) @(negedge clk);
        cfg_brr = DIV_W'(5);
        cfg_len = LEN_W'(4);
        wait_idle();
        chk(win_min == 10 && win_max == 10, "R11", win_max, 10);
        cur_len = 4;
        send(16'h000B, 16'h0006);
        wait_idle();
        chk(win_min == 6 && win_max == 6, "R11", win_max, 6);

        chk(exp_mosi.size() == 0, "R6", exp_mosi.size(), 0);
        chk(exp_rx.size() == 0, "R10", exp_rx.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tb_checks + mon_checks, tb_fails + mon_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog: run did not finish, got 0, expected 1");
        $display("[TB] %0d tests run, %0d failed", tb_checks + mon_checks + 1, tb_fails + mon_fails + 1);
        $finish;
    end
endmodule